// File: doc/BRIEF.md
# Energy-to-Pulse Rate Generator

This block turns two signed per-sample energy figures into two trains of output pulses. One train is for real energy and one is for reactive energy. On every accepted sample, each channel takes the magnitude of its value and multiplies it by a shared rate register. It adds the product to a remainder accumulator. When the accumulator reaches the threshold 2^(W+R-1), the channel emits a one-clock pulse, subtracts the threshold and keeps the rest. Because the remainder is kept, pulse timing stays even and no energy is lost between pulses.

A 4-bit mode code picks where each channel's value comes from. Code 0 selects the internally computed summed energy. Code 15 selects the values written by the controlling processor, and any other code is handled the same way as 15. Each channel has a direction output that records the sign of the value that caused its latest pulse. Each channel can also be routed to a dedicated output pin by its own enable bit. A routed pin also raises a one-cycle interrupt so that software can count pulses.

The sample interface is valid/ready. The block never applies back-pressure: `smp_ready` is high whenever reset is released, and a sample is taken on every clock edge where `smp_valid` and `smp_ready` are both high.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is low, and right after it is released, both pulse outputs, both direction outputs, both pins, both interrupts and both accumulators are zero.
- R2: `smp_ready` is 1 whenever reset is high, so a sample is accepted on every clock edge with `smp_valid` = 1.
- R3: After reset, N accepted samples with a constant value v and a constant rate r produce exactly floor(N·|v|·r / 2^(W+R-1)) pulses on that channel; the remainder carries over between samples.
- R4: A pulse is high for one clock, in the cycle after the accepted sample that made the accumulator reach the threshold. There is at most one pulse per accepted sample.
- R5: Clock edges with `smp_valid` = 0 leave the accumulators unchanged and produce no pulses.
- R6: Mode code 0 selects `int_real`/`int_reac`; code 15 selects `ext_real`/`ext_reac`; every other code behaves as code 15.
- R7: `dir_*` is 1 when the value that caused the latest pulse was negative and 0 when it was positive. It holds its value between pulses.
- R8: `pin_*` equals `pulse_*` when the matching enable is 1 and stays 0 when it is 0. `irq_*` is high in exactly the cycles where `pin_*` is high.
- R9: The real and reactive channels count independently, each from its own source value and with the shared rate.
- R10: A rate of 0 or a source value of 0 produces no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_code | input | 4 | Source select: 0 internal, anything else external |
| ext_real | input | W | Processor-written real value (signed) |
| ext_reac | input | W | Processor-written reactive value (signed) |
| int_real | input | W | Internally summed real energy (signed) |
| int_reac | input | W | Internally summed reactive energy (signed) |
| rate | input | R | Shared unsigned rate multiplier |
| smp_valid | input | 1 | Sample strobe (valid) |
| smp_ready | output | 1 | Always ready out of reset |
| pin_en_real | input | 1 | Route real pulses to pin |
| pin_en_reac | input | 1 | Route reactive pulses to pin |
| pulse_real | output | 1 | One-clock real energy pulse |
| pulse_reac | output | 1 | One-clock reactive energy pulse |
| dir_real | output | 1 | Sign of real value at latest pulse |
| dir_reac | output | 1 | Sign of reactive value at latest pulse |
| pin_real | output | 1 | Routed real pulse pin |
| pin_reac | output | 1 | Routed reactive pulse pin |
| irq_real | output | 1 | Interrupt from routed real pin |
| irq_reac | output | 1 | Interrupt from routed reactive pin |

## Verification
The counting rule is tried with several patterns:
- A value that fills exactly a quarter of the threshold per sample, which checks the basic scaling.
- A remainder-leaving product, which separates a design that keeps the remainder from one that clears it.
- The most negative value at the highest rate, which exercises magnitude handling and back-to-back pulses.

Gaps in `smp_valid` show that idle edges add nothing. Zero rate and zero value confirm that no pulses appear. Swapping the mode code between 0, 15 and an in-between code, with different external and internal values, shows which source feeds each channel. Sign changes test that the direction output is captured only when a pulse fires.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam logic [3:0] MODE_INTERNAL = 4'd0;
  localparam logic [3:0] MODE_EXTERNAL = 4'd15;

  function automatic logic use_internal(input logic [3:0] code);
    return code == MODE_INTERNAL;
  endfunction
endpackage

// File: rtl/epg_src_sel.sv
module epg_src_sel #(
  parameter int W = 16
) (
  input  logic [3:0]          mode_code,
  input  logic signed [W-1:0] ext_a,
  input  logic signed [W-1:0] ext_b,
  input  logic signed [W-1:0] int_a,
  input  logic signed [W-1:0] int_b,
  output logic signed [W-1:0] src_a,
  output logic signed [W-1:0] src_b
);
  import epg_pkg::*;

  logic pick_int;

  always_comb begin
    pick_int = use_internal(mode_code);
    src_a    = pick_int ? int_a : ext_a;
    src_b    = pick_int ? int_b : ext_b;
  end
endmodule

// File: rtl/epg_rate_chan.sv
module epg_rate_chan #(
  parameter int W = 16,
  parameter int R = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic signed [W-1:0] val,
  input  logic [R-1:0]        rate,
  output logic                pulse,
  output logic                dir
);
  localparam int TH = W + R - 1;
  localparam int AW = TH + 1;
  localparam logic [AW-1:0] THRESH = {1'b1, {TH{1'b0}}};

  logic [W-1:0]  mag;
  logic [AW-1:0] scaled;
  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic          reach;

  always_comb begin
    mag    = val[W-1] ? ((~val) + W'(1)) : val;
    scaled = AW'(mag) * AW'(rate);
    sum    = acc + scaled;
    reach  = sum >= THRESH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      pulse <= 1'b0;
      dir   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (stb) begin
        if (reach) begin
          acc   <= sum - THRESH;
          pulse <= 1'b1;
          dir   <= val[W-1];
        end else begin
          acc <= sum;
        end
      end
    end
  end

  p_acc_below_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc < THRESH);
  p_pulse_follows_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(stb));
  p_idle_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(acc));
  p_dir_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |-> $stable(dir));
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen #(
  parameter int W = 16,
  parameter int R = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          mode_code,
  input  logic signed [W-1:0] ext_real,
  input  logic signed [W-1:0] ext_reac,
  input  logic signed [W-1:0] int_real,
  input  logic signed [W-1:0] int_reac,
  input  logic [R-1:0]        rate,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic                pin_en_real,
  input  logic                pin_en_reac,
  output logic                pulse_real,
  output logic                pulse_reac,
  output logic                dir_real,
  output logic                dir_reac,
  output logic                pin_real,
  output logic                pin_reac,
  output logic                irq_real,
  output logic                irq_reac
);
  localparam int NCH = 2;

  logic signed [W-1:0] src [NCH];
  logic [NCH-1:0]      pls;
  logic [NCH-1:0]      dr;
  logic [NCH-1:0]      en;
  logic [NCH-1:0]      pin;
  logic                take;

  assign smp_ready = rst_n;
  assign take      = smp_valid & smp_ready;
  assign en        = {pin_en_reac, pin_en_real};

  epg_src_sel #(.W(W)) u_sel (
    .mode_code(mode_code),
    .ext_a(ext_real), .ext_b(ext_reac),
    .int_a(int_real), .int_b(int_reac),
    .src_a(src[0]),   .src_b(src[1])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    epg_rate_chan #(.W(W), .R(R)) u_chan (
      .clk(clk), .rst_n(rst_n), .stb(take),
      .val(src[c]), .rate(rate),
      .pulse(pls[c]), .dir(dr[c])
    );
    assign pin[c] = pls[c] & en[c];
  end

  assign pulse_real = pls[0];
  assign pulse_reac = pls[1];
  assign dir_real   = dr[0];
  assign dir_reac   = dr[1];
  assign pin_real   = pin[0];
  assign pin_reac   = pin[1];
  assign irq_real   = pin[0];
  assign irq_reac   = pin[1];

  p_ready_out_of_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);
  p_pin_needs_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_real |-> pulse_real) and (pin_reac |-> pulse_reac));
endmodule

// File: tb/energy_pulse_gen_test.sv
module energy_pulse_gen_test;
  localparam int W = 16;
  localparam int R = 8;
  localparam longint THR = 64'd1 << (W + R - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] mode_code = 4'd15;
  logic signed [W-1:0] ext_real = '0, ext_reac = '0, int_real = '0, int_reac = '0;
  logic [R-1:0] rate = '0;
  logic smp_valid = 1'b0;
  logic pin_en_real = 1'b0, pin_en_reac = 1'b0;
  logic smp_ready, pulse_real, pulse_reac, dir_real, dir_reac;
  logic pin_real, pin_reac, irq_real, irq_reac;

  int checks = 0;
  int errors = 0;
  int n_pr = 0, n_pq = 0, n_pinr = 0, n_pinq = 0, n_irqr = 0, n_irqq = 0;

  always #2.5 clk = ~clk;

  energy_pulse_gen #(.W(W), .R(R)) uut (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code),
    .ext_real(ext_real), .ext_reac(ext_reac),
    .int_real(int_real), .int_reac(int_reac),
    .rate(rate), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .pin_en_real(pin_en_real), .pin_en_reac(pin_en_reac),
    .pulse_real(pulse_real), .pulse_reac(pulse_reac),
    .dir_real(dir_real), .dir_reac(dir_reac),
    .pin_real(pin_real), .pin_reac(pin_reac),
    .irq_real(irq_real), .irq_reac(irq_reac)
  );

  always @(negedge clk) begin
    n_pr   <= n_pr + int'(pulse_real);
    n_pq   <= n_pq + int'(pulse_reac);
    n_pinr <= n_pinr + int'(pin_real);
    n_pinq <= n_pinq + int'(pin_reac);
    n_irqr <= n_irqr + int'(irq_real);
    n_irqq <= n_irqq + int'(irq_reac);
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_cnt(input int n, input longint v, input longint r);
    longint m = (v < 0) ? -v : v;
    return (longint'(n) * m * r) / THR;
  endfunction

  task automatic clear_counts();
    @(posedge clk); #1;
    n_pr = 0; n_pq = 0; n_pinr = 0; n_pinq = 0; n_irqr = 0; n_irqq = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_counts();
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_valid = 1'b1;
    end
    @(negedge clk); smp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; ext_real = 16'sd20000; rate = 8'd255; smp_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pulses in reset", {pulse_real, pulse_reac, pin_real, pin_reac}, 0);
    check("R1 dir in reset", {dir_real, dir_reac}, 0);
    smp_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R2 ready", smp_ready, 1);
    check("R1 outputs after reset", {pulse_real, pulse_reac, irq_real, irq_reac}, 0);
  endtask

  task automatic t_count(input longint vr, input longint vq, input longint r, input int n);
    do_reset();
    mode_code = 4'd15; ext_real = W'(vr); ext_reac = W'(vq); rate = R'(r);
    strobes(n);
    check("R3 real count", n_pr, expect_cnt(n, vr, r));
    check("R9 reac count", n_pq, expect_cnt(n, vq, r));
  endtask

  task automatic t_timing();
    do_reset();
    mode_code = 4'd15; ext_real = 16'sd32767; rate = 8'd255;
    @(negedge clk); smp_valid = 1'b1;
    @(negedge clk);
    check("R4 no pulse after first sample", pulse_real, 0);
    @(negedge clk); smp_valid = 1'b0;
    check("R4 pulse after crossing sample", pulse_real, 1);
    @(negedge clk);
    check("R4 pulse lasts one clock", pulse_real, 0);
  endtask

  task automatic t_gaps();
    do_reset();
    mode_code = 4'd15; ext_real = 16'sd16384; rate = 8'd128;
    strobes(3);
    repeat (20) @(negedge clk);
    check("R5 idle edges add nothing", n_pr, 0);
    strobes(1);
    check("R5 fourth sample completes pulse", n_pr, 1);
  endtask

  task automatic t_mode(input logic [3:0] m, input longint expr);
    do_reset();
    mode_code = m; ext_real = 16'sd16384; int_real = 16'sd0;
    ext_reac = 16'sd0; int_reac = -16'sd16384; rate = 8'd128;
    strobes(8);
    check($sformatf("R6 mode %0d real", m), n_pr, expr);
    check($sformatf("R6 mode %0d reac", m), n_pq, 2 - expr);
  endtask

  task automatic t_dir();
    do_reset();
    mode_code = 4'd15; ext_real = -16'sd16384; rate = 8'd255;
    strobes(3);
    check("R7 negative dir", dir_real, 1);
    ext_real = 16'sd16384;
    strobes(1);
    check("R7 dir held without pulse", dir_real, 1);
    strobes(1);
    check("R7 positive dir on pulse", dir_real, 0);
  endtask

  task automatic t_pins();
    do_reset();
    mode_code = 4'd15; ext_real = 16'sd16384; ext_reac = 16'sd16384; rate = 8'd128;
    pin_en_real = 1'b1; pin_en_reac = 1'b0;
    strobes(8);
    check("R8 real pin routed", n_pinr, 2);
    check("R8 real irq", n_irqr, 2);
    check("R8 reac pin blocked", n_pinq + n_irqq, 0);
    check("R8 reac pulses still present", n_pq, 2);
    pin_en_real = 1'b0;
  endtask

  task automatic t_zero();
    do_reset();
    mode_code = 4'd15; ext_real = 16'sd32767; ext_reac = 16'sd0; rate = 8'd0;
    strobes(10);
    check("R10 zero rate", n_pr, 0);
    rate = 8'd200;
    strobes(10);
    check("R10 zero value", n_pq, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_count(16384, -16384, 128, 8);
        t_count(3000, -1, 200, 50);
        t_count(-32768, 32767, 255, 5);
        t_count(-32768, 7, 255, 200);
        t_timing();
        t_gaps();
        t_mode(4'd0, 0);
        t_mode(4'd15, 2);
        t_mode(4'd6, 2);
        t_dir();
        t_pins();
        t_zero();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule